// File: doc/BRIEF.md
# Shared Semaphore Bank for Three Masters

This block holds a bank of hardware semaphores that three bus masters share. Software gives each semaphore its meaning. The hardware only makes sure that taking a semaphore and handing it on are atomic, so that two masters can never both believe they own the same one.

A master can take a semaphore in two ways:

- **Direct claim (a read).** It either wins at once or is refused. The answer comes back on a registered response one cycle later.
- **Indirect claim (a write).** If the semaphore is busy, the master joins a first-in, first-out waiting line kept for that semaphore. When the owner releases it, ownership passes straight to the oldest waiter.

Every ownership gained through an indirect claim sets a sticky bit in that master's grant-status vector. A master's interrupt stays high while any bit of its vector is set. The master clears bits with a write-1-to-clear access.

Each master has its own access port: valid, write, select, index and data. All three ports may be active in the same clock cycle. Accesses that land in one cycle are applied in master-ID order, so master 0's access takes effect first and master 2 sees the outcome of both others.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is free, every queue is empty, every grant-status bit is 0 and every interrupt is low.
- R2: A read (write=0, select=0) of a free semaphore makes the requester its owner. In the next cycle `rsp_valid` is high, response bit 0 is 1 and response bits [2:1] hold the requester's ID.
- R3: A read of a held semaphore is refused. Response bit 0 is 0, bits [2:1] give the holder's ID, and ownership and queue are left unchanged.
- R4: A write with data bit 1 set (indirect claim) to a free semaphore makes the requester its owner in that cycle. It also sets the requester's grant-status bit for that index.
- R5: An indirect claim to a semaphore held by another master appends the requester to that semaphore's FIFO. Each master appears at most once. A repeated claim, or a claim by the owner, is ignored.
- R6: A write with data bit 0 set (release) by the owner hands the semaphore to the head of its FIFO and sets that master's grant-status bit. If the FIFO is empty, the semaphore becomes free.
- R7: A release written by a master that is not the owner has no effect.
- R8: When several masters access in the same cycle, the accesses apply in ascending master-ID order, each seeing the result of the lower IDs. Two same-cycle claims of one free semaphore therefore grant only the lowest ID.
- R9: `irq[m]` is high exactly while master m's grant-status vector is non-zero. A write with select=1 and data bit 0 set clears bit `index` of the writer's own vector. Reads with select=1 produce no response.
- R10: If a grant sets a status bit in the same cycle as its owner's clear of that bit, the bit ends up set.
- R11: Writes never produce a response; only semaphore reads do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 3 | Per-master access strobe |
| acc_write | input | 3 | Per-master access kind: 1 = write, 0 = read |
| acc_sel | input | 3 | Per-master target: 0 = semaphore, 1 = own grant-status vector |
| acc_index | input | 18 | Per-master semaphore index, 6 bits each; master m uses bits [6m+5:6m] |
| acc_wdata | input | 6 | Per-master write data, 2 bits each: bit 0 = release / clear, bit 1 = indirect claim |
| rsp_valid | output | 3 | Per-master response strobe, one cycle after a semaphore read |
| rsp_data | output | 9 | Per-master response, 3 bits each: bit 0 = granted, bits [2:1] = owner ID |
| irq | output | 3 | Per-master grant interrupt (level) |
| grant_status | output | 192 | Per-master sticky grant vectors, 64 bits each; master m uses bits [64m+63:64m] |

## Verification
Two functions can fall on the same cycle:

- **Status set against status clear.** A release by one master hands a semaphore to a queued master, setting that master's status bit. In the same cycle the queued master writes a clear of that very bit. The bench stages this on purpose and expects the bit to remain set with the interrupt still high.
- **Competing claims.** Two or three masters claim one semaphore in the same cycle, both by direct reads and in a random phase that limits all traffic to three indices.

In every case a behavioural reference model, fed the same inputs in ascending ID order, predicts the responses, the status vectors and the interrupts, and these are compared at every clock.

// File: rtl/sem_pkg.sv
package sem_pkg;
  parameter int SEM_MASTERS = 3;
  parameter int SEM_COUNT   = 64;
  localparam int MIDW = $clog2(SEM_MASTERS);
  localparam int IDXW = $clog2(SEM_COUNT);
  localparam int CNTW = $clog2(SEM_MASTERS + 1);
  localparam int WDW  = 2;
  localparam int RSPW = MIDW + 1;

  typedef struct packed {
    logic                            held;
    logic [MIDW-1:0]                 owner;
    logic [CNTW-1:0]                 qcnt;
    logic [SEM_MASTERS-1:0][MIDW-1:0] q;
  } sem_ent_t;
endpackage

// File: rtl/sem_stage.sv
module sem_stage
  import sem_pkg::*;
#(
  parameter int MID = 0
) (
  input  sem_ent_t        st_i [SEM_COUNT],
  output sem_ent_t        st_o [SEM_COUNT],
  input  logic            acc_v,
  input  logic            acc_w,
  input  logic            acc_s,
  input  logic [IDXW-1:0] acc_idx,
  input  logic [WDW-1:0]  acc_wd,
  output logic            rsp_g,
  output logic [MIDW-1:0] rsp_own,
  output logic            gnt_v,
  output logic [MIDW-1:0] gnt_m,
  output logic [IDXW-1:0] gnt_idx
);
  localparam logic [MIDW-1:0] ME = MIDW'(MID);

  sem_ent_t e;
  logic     inq;

  always_comb begin
    st_o    = st_i;
    e       = st_i[acc_idx];
    rsp_g   = 1'b0;
    rsp_own = e.owner;
    gnt_v   = 1'b0;
    gnt_m   = ME;
    gnt_idx = acc_idx;
    inq     = 1'b0;
    for (int k = 0; k < SEM_MASTERS; k++) begin
      if ((CNTW'(k) < e.qcnt) && (e.q[k] == ME)) inq = 1'b1;
    end
    if (acc_v && !acc_s) begin
      if (!acc_w) begin
        // direct claim: test-and-set
        if (!e.held) begin
          e.held  = 1'b1;
          e.owner = ME;
          rsp_g   = 1'b1;
        end
        rsp_own = e.owner;
      end else begin
        // release, only honoured from the owner
        if (acc_wd[0] && e.held && (e.owner == ME)) begin
          if (e.qcnt != '0) begin
            e.owner = e.q[0];
            for (int k = 0; k < SEM_MASTERS - 1; k++) e.q[k] = e.q[k+1];
            e.q[SEM_MASTERS-1] = '0;
            e.qcnt  = e.qcnt - 1'b1;
            gnt_v   = 1'b1;
            gnt_m   = e.owner;
          end else begin
            e.held = 1'b0;
          end
        end
        // indirect claim
        if (acc_wd[1]) begin
          if (!e.held) begin
            e.held  = 1'b1;
            e.owner = ME;
            gnt_v   = 1'b1;
            gnt_m   = ME;
          end else if ((e.owner != ME) && !inq && (e.qcnt < CNTW'(SEM_MASTERS))) begin
            e.q[e.qcnt[MIDW-1:0]] = ME;
            e.qcnt = e.qcnt + 1'b1;
          end
        end
      end
      st_o[acc_idx] = e;
    end
  end
endmodule

// File: rtl/sem_status.sv
module sem_status
  import sem_pkg::*;
#(
  parameter int MID = 0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SEM_MASTERS-1:0]      gnt_v,
  input  logic [SEM_MASTERS*MIDW-1:0] gnt_m,
  input  logic [SEM_MASTERS*IDXW-1:0] gnt_idx,
  input  logic                        clr_en,
  input  logic [IDXW-1:0]             clr_idx,
  output logic [SEM_COUNT-1:0]        status,
  output logic                        irq
);
  logic [SEM_COUNT-1:0] st_q, st_d, set_v, clr_v;
  logic                 st_en;

  always_comb begin
    set_v = '0;
    for (int s = 0; s < SEM_MASTERS; s++) begin
      if (gnt_v[s] && (gnt_m[s*MIDW +: MIDW] == MIDW'(MID)))
        set_v[gnt_idx[s*IDXW +: IDXW]] = 1'b1;
    end
    clr_v = '0;
    if (clr_en) clr_v[clr_idx] = 1'b1;
    st_d  = (st_q & ~clr_v) | set_v;
    st_en = (set_v != '0) || clr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= '0;
    else if (st_en) st_q <= st_d;
  end

  assign status = st_q;
  assign irq    = |st_q;

  AST_STICKY_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~clr_v) != '0) |=> (($past(st_q) & ~$past(clr_v) & ~st_q) == '0)); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_v != '0) |=> ((st_q & $past(set_v)) == $past(set_v))); // R10
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [SEM_MASTERS-1:0]        acc_valid,
  input  logic [SEM_MASTERS-1:0]        acc_write,
  input  logic [SEM_MASTERS-1:0]        acc_sel,
  input  logic [SEM_MASTERS*IDXW-1:0]   acc_index,
  input  logic [SEM_MASTERS*WDW-1:0]    acc_wdata,
  output logic [SEM_MASTERS-1:0]        rsp_valid,
  output logic [SEM_MASTERS*RSPW-1:0]   rsp_data,
  output logic [SEM_MASTERS-1:0]        irq,
  output logic [SEM_MASTERS*SEM_COUNT-1:0] grant_status
);
  // reset: asynchronous assert, synchronous release
  logic rs_a, rs_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end
  logic rst_s;
  assign rst_s = rs_b;

  sem_ent_t st_q     [SEM_COUNT];
  sem_ent_t st_chain [SEM_MASTERS+1][SEM_COUNT];

  logic [SEM_MASTERS-1:0]        rsp_g;
  logic [SEM_MASTERS*MIDW-1:0]   rsp_own;
  logic [SEM_MASTERS-1:0]        gnt_v;
  logic [SEM_MASTERS*MIDW-1:0]   gnt_m;
  logic [SEM_MASTERS*IDXW-1:0]   gnt_idx;

  assign st_chain[0] = st_q;

  for (genvar m = 0; m < SEM_MASTERS; m++) begin : g_master
    sem_stage #(.MID(m)) u_stage (
      .st_i    (st_chain[m]),
      .st_o    (st_chain[m+1]),
      .acc_v   (acc_valid[m]),
      .acc_w   (acc_write[m]),
      .acc_s   (acc_sel[m]),
      .acc_idx (acc_index[m*IDXW +: IDXW]),
      .acc_wd  (acc_wdata[m*WDW +: WDW]),
      .rsp_g   (rsp_g[m]),
      .rsp_own (rsp_own[m*MIDW +: MIDW]),
      .gnt_v   (gnt_v[m]),
      .gnt_m   (gnt_m[m*MIDW +: MIDW]),
      .gnt_idx (gnt_idx[m*IDXW +: IDXW])
    );

    sem_status #(.MID(m)) u_status (
      .clk     (clk),
      .rst_n   (rst_s),
      .gnt_v   (gnt_v),
      .gnt_m   (gnt_m),
      .gnt_idx (gnt_idx),
      .clr_en  (acc_valid[m] && acc_sel[m] && acc_write[m] && acc_wdata[m*WDW]),
      .clr_idx (acc_index[m*IDXW +: IDXW]),
      .status  (grant_status[m*SEM_COUNT +: SEM_COUNT]),
      .irq     (irq[m])
    );
  end

  // semaphore state register
  logic st_en;
  assign st_en = |(acc_valid & ~acc_sel);

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      for (int s = 0; s < SEM_COUNT; s++) st_q[s] <= '0;
    end else if (st_en) begin
      st_q <= st_chain[SEM_MASTERS];
    end
  end

  // response path
  logic [SEM_MASTERS-1:0]      rv_d, rv_q;
  logic [SEM_MASTERS*RSPW-1:0] rd_d, rd_q;
  logic [SEM_MASTERS*IDXW-1:0] ri_q;

  always_comb begin
    rv_d = acc_valid & ~acc_write & ~acc_sel;
    for (int m = 0; m < SEM_MASTERS; m++)
      rd_d[m*RSPW +: RSPW] = {rsp_own[m*MIDW +: MIDW], rsp_g[m]};
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      rv_q <= '0;
      rd_q <= '0;
      ri_q <= '0;
    end else begin
      rv_q <= rv_d;
      if (rv_d != '0) begin
        rd_q <= rd_d;
        ri_q <= acc_index;
      end
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_data  = rd_q;

  for (genvar s = 0; s < SEM_COUNT; s++) begin : g_chk
    AST_FREE_EMPTY: assert property (@(posedge clk) disable iff (!rst_s)
      !st_q[s].held |-> (st_q[s].qcnt == '0)); // R6
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_s)
      st_q[s].qcnt <= CNTW'(SEM_MASTERS - 1)); // R5
  end

  for (genvar m = 0; m < SEM_MASTERS; m++) begin : g_rchk
    AST_GRANT_SELF: assert property (@(posedge clk) disable iff (!rst_s)
      (rv_q[m] && rd_q[m*RSPW]) |-> (rd_q[m*RSPW+1 +: MIDW] == MIDW'(m))); // R2
    for (genvar n = m + 1; n < SEM_MASTERS; n++) begin : g_pair
      AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_s)
        !(rv_q[m] && rv_q[n] && rd_q[m*RSPW] && rd_q[n*RSPW] &&
          (ri_q[m*IDXW +: IDXW] == ri_q[n*IDXW +: IDXW]))); // R8
    end
  end
endmodule

// File: tb/sem_bank_tb.sv
module sem_bank_tb;
  logic        clk;
  logic        rst_n;
  logic [2:0]  v, w, s;
  logic [17:0] idx;
  logic [5:0]  wd;
  logic [2:0]  rsp_valid;
  logic [8:0]  rsp_data;
  logic [2:0]  irq;
  logic [191:0] grant_status;

  sem_bank u_dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(v), .acc_write(w), .acc_sel(s),
    .acc_index(idx), .acc_wdata(wd), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .irq(irq), .grant_status(grant_status)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit run   = 0;
  bit done  = 0;
  string cur_req = "R1";

  // reference model
  bit        held [64];
  int        own  [64];
  int        qa   [64][3];
  int        qn   [64];
  bit [63:0] st   [3];
  bit [2:0]  exp_rv;
  bit [2:0]  exp_rd [3];

  task automatic chk(string r, logic [255:0] act, logic [255:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (run) begin
      bit [63:0] setb [3];
      bit [63:0] clrb [3];
      for (int m = 0; m < 3; m++) begin setb[m] = '0; clrb[m] = '0; end
      exp_rv = '0;
      for (int m = 0; m < 3; m++) begin
        if (v[m]) begin
          int ix;
          ix = int'(idx[m*6 +: 6]);
          if (s[m]) begin
            if (w[m] && wd[m*2]) clrb[m][ix] = 1'b1;
          end else if (!w[m]) begin
            bit g;
            g = 1'b0;
            if (!held[ix]) begin held[ix] = 1; own[ix] = m; g = 1; end
            exp_rv[m] = 1'b1;
            exp_rd[m] = {own[ix][1:0], g};
          end else begin
            if (wd[m*2] && held[ix] && own[ix] == m) begin
              if (qn[ix] > 0) begin
                own[ix] = qa[ix][0];
                qa[ix][0] = qa[ix][1];
                qa[ix][1] = qa[ix][2];
                qn[ix]--;
                setb[own[ix]][ix] = 1'b1;
              end else held[ix] = 0;
            end
            if (wd[m*2+1]) begin
              if (!held[ix]) begin
                held[ix] = 1; own[ix] = m; setb[m][ix] = 1'b1;
              end else if (own[ix] != m) begin
                bit found;
                found = 0;
                for (int k = 0; k < qn[ix]; k++) if (qa[ix][k] == m) found = 1;
                if (!found) begin qa[ix][qn[ix]] = m; qn[ix]++; end
              end
            end
          end
        end
      end
      for (int m = 0; m < 3; m++) st[m] = (st[m] & ~clrb[m]) | setb[m];
    end
  end

  always @(negedge clk) begin
    if (run && !done) begin
      bit ok;
      ok = (rsp_valid === exp_rv);
      for (int m = 0; m < 3; m++) begin
        if (exp_rv[m] && rsp_data[m*3 +: 3] !== exp_rd[m]) ok = 0;
        if (grant_status[m*64 +: 64] !== st[m]) ok = 0;
        if (irq[m] !== (st[m] != 0)) ok = 0;
      end
      total++;
      if (!ok) begin
        bad++;
        $display("FAIL %s model mismatch actual rv=%b irq=%b expected rv=%b irq=%b",
                 cur_req, rsp_valid, irq, exp_rv, {st[2] != 0, st[1] != 0, st[0] != 0});
      end
    end
  end

  task automatic acc(int m, bit wr, bit sl, int ix, int d);
    v[m] = 1'b1; w[m] = wr; s[m] = sl;
    idx[m*6 +: 6] = 6'(ix);
    wd[m*2 +: 2]  = 2'(d);
  endtask

  task automatic step();
    @(negedge clk);
    v = '0; w = '0; s = '0; idx = '0; wd = '0;
  endtask

  task automatic finish_up();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    finish_up();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin held[i] = 0; own[i] = 0; qn[i] = 0; end
    for (int m = 0; m < 3; m++) begin st[m] = '0; exp_rd[m] = '0; end
    exp_rv = '0;
    v = '0; w = '0; s = '0; idx = '0; wd = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run = 1;
    // R1 reset state
    chk("R1", {253'd0, irq}, 256'd0);
    chk("R1", {64'd0, grant_status}, 256'd0);
    chk("R1", {253'd0, rsp_valid}, 256'd0);

    // R2 direct claim of free semaphore
    cur_req = "R2";
    acc(0, 0, 0, 5, 0); step();
    chk("R2", {253'd0, rsp_valid}, 256'd1);
    chk("R2", {253'd0, rsp_data[2:0]}, 256'b001);

    // R3 refused claim
    cur_req = "R3";
    acc(1, 0, 0, 5, 0); step();
    chk("R3", {253'd0, rsp_data[5:3]}, 256'b000);

    // R5 queueing, duplicates ignored; R11 writes give no response
    cur_req = "R5";
    acc(1, 1, 0, 5, 2); step();
    chk("R11", {253'd0, rsp_valid}, 256'd0);
    acc(2, 1, 0, 5, 2); step();
    acc(1, 1, 0, 5, 2); step();
    // R7 non-owner release ignored
    cur_req = "R7";
    acc(2, 1, 0, 5, 1); step();
    acc(2, 0, 0, 5, 0); step();
    chk("R7", {253'd0, rsp_data[8:6]}, 256'b000);

    // R6 hand-over in FIFO order
    cur_req = "R6";
    acc(0, 1, 0, 5, 1); step();
    chk("R6", {255'd0, grant_status[64+5]}, 256'd1);
    chk("R6", {253'd0, irq}, 256'b010);
    acc(1, 1, 0, 5, 1); step();
    chk("R6", {255'd0, grant_status[128+5]}, 256'd1);
    acc(2, 1, 0, 5, 1); step();
    acc(1, 0, 0, 5, 0); step();
    chk("R6", {253'd0, rsp_data[5:3]}, 256'b011);

    // R8 three-way collision
    cur_req = "R8";
    acc(0, 0, 0, 9, 0); acc(1, 0, 0, 9, 0); acc(2, 0, 0, 9, 0); step();
    chk("R8", {247'd0, rsp_data}, {247'd0, 3'b000, 3'b000, 3'b001});

    // R4 indirect claim of free semaphore
    cur_req = "R4";
    acc(2, 1, 0, 63, 2); step();
    chk("R4", {255'd0, grant_status[128+63]}, 256'd1);

    // R9 clear
    cur_req = "R9";
    acc(1, 1, 1, 5, 1); step();
    chk("R9", {255'd0, irq[1]}, 256'd0);
    acc(1, 0, 1, 5, 0); step();
    chk("R9", {253'd0, rsp_valid}, 256'd0);

    // R10 set beats clear in the same cycle
    cur_req = "R10";
    acc(0, 1, 0, 7, 2); step();
    acc(0, 1, 0, 7, 1); step();
    acc(1, 0, 0, 7, 0); step();
    acc(0, 1, 0, 7, 2); step();
    acc(0, 1, 1, 7, 1); acc(1, 1, 0, 7, 1); step();
    chk("R10", {255'd0, grant_status[7]}, 256'd1);
    chk("R10", {255'd0, irq[0]}, 256'd1);

    // R8 random contention on few indices
    cur_req = "R8";
    for (int n = 0; n < 600; n++) begin
      for (int m = 0; m < 3; m++) begin
        if (($urandom % 3) != 0)
          acc(m, 1'($urandom), (($urandom % 6) == 0), int'($urandom % 3), int'($urandom % 4));
      end
      step();
    end
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule